// File: doc/BRIEF.md
# Serial Transmitter with Self-Clearing Request-to-Send

This block serializes characters onto an asynchronous serial line. A CPU writes a character into a one-entry holding register. On a baud tick the character moves into a frame shift register and is sent as a start bit, the data bits least significant first, and one or two stop bits. Each bit lasts a fixed number of baud ticks. Two status outputs report whether the holding register can take a write and whether everything has been sent. Both outputs are forced low while the transmitter is disabled.

The block also drives a request-to-send output that software sets and clears. In the automatic mode, hardware clears this output by itself to mark the end of a message. The clear happens one bit time after the last stop bit has left the line, and only once the transmitter has been disabled and both registers are empty. Software may disable the transmitter as soon as the final character is in the holding register: that character is still sent. The automatic clear still happens if the disable comes after the line has already gone idle.

Top module: `uart_tx_rts`

## Requirements
- R1: After reset the line is high, the request-to-send output is low, both status outputs are low, and the transmitter is disabled.
- R2: A frame is one low start bit, then `DATA_W` data bits least significant first, then one stop bit when `twoStop` is 0 or two when it is 1, all high. Each bit lasts `TICKS_PER_BIT` baud ticks. The line is high whenever no frame is being sent.
- R3: A write is taken into the holding register only while the transmitter is enabled and the holding register is empty. A write at any other time is ignored and produces no frame.
- R4: `txReady` is high while the transmitter is enabled and the holding register is empty. `txEmpty` is high while the transmitter is enabled and both registers are empty. Both are low while the transmitter is disabled.
- R5: When a character waits in the holding register, its start bit follows the last stop bit of the previous frame with no idle time between them.
- R6: Characters already in the holding or shift register when the transmitter is disabled are still sent in full.
- R7: In automatic mode (`autoRtsMode`=1), with the transmitter disabled, request-to-send clears exactly `TICKS_PER_BIT` baud ticks after the last stop bit ends.
- R8: In automatic mode, disabling the transmitter after the line is already idle still clears request-to-send, `TICKS_PER_BIT` baud ticks after the disable takes effect.
- R9: With `autoRtsMode`=0, request-to-send changes only through `rtsSetCmd` and `rtsClrCmd`.
- R10: A software set of request-to-send while an automatic clear is pending restarts the delay, so the clear comes a full bit time after that set.
- R11: `rtsSetCmd` sets request-to-send and `rtsClrCmd` clears it. When both are asserted in the same cycle the set wins, and a set also wins over an automatic clear in the same cycle.
- R12: `txEnCmd` enables the transmitter and `txDisCmd` disables it. When both are asserted in the same cycle the disable wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| baudTick | input | 1 | One-cycle pulse; `TICKS_PER_BIT` pulses make one bit time |
| txEnCmd | input | 1 | Enable-transmitter command strobe |
| txDisCmd | input | 1 | Disable-transmitter command strobe |
| wrValid | input | 1 | Holding-register write strobe |
| wrData | input | DATA_W | Character to write |
| twoStop | input | 1 | 1 selects two stop bits; sampled when a frame starts |
| autoRtsMode | input | 1 | 1 enables the automatic request-to-send clear |
| rtsSetCmd | input | 1 | Sets the request-to-send bit |
| rtsClrCmd | input | 1 | Clears the request-to-send bit |
| txd | output | 1 | Serial line, idle high |
| rtsOut | output | 1 | Request-to-send bit |
| txReady | output | 1 | Holding register can take a write |
| txEmpty | output | 1 | Both registers are empty |

## Verification
The hardest case to reach is the restart of a pending automatic clear. It needs the transmitter disabled, both registers empty, automatic mode on and request-to-send set. A second set must then arrive inside the few-cycle window before the delay expires. The stimulus disables an idle transmitter and sets the bit. It sets the bit again partway through the delay, then checks that the output is still high at a cycle where an unrestarted timer would already have cleared it. It then checks that the clear lands one full bit time after the second set. The end-of-message case is reached differently: two characters are queued back to back and the transmitter is disabled at once, and the bench checks the cycle of the clear against the start of the last frame.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  typedef struct packed {
    logic holdLoad;
    logic shiftLoad;
    logic shiftAdv;
  } txStrobes_t;
endpackage

// File: rtl/uart_tx_dp.sv
module uart_tx_dp
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobes_t        strb,
  input  logic [DATA_W-1:0] wrData,
  output logic              txd
);
  localparam int FR_W = DATA_W + 3;

  logic [DATA_W-1:0] holdReg;
  logic [FR_W-1:0]   frameReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) holdReg <= '0;
    else if (strb.holdLoad) holdReg <= wrData;
  end

  // Shift register refills with ones, so it idles at a high line.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) frameReg <= '1;
    else if (strb.shiftLoad) frameReg <= {2'b11, holdReg, 1'b0};
    else if (strb.shiftAdv) frameReg <= {1'b1, frameReg[FR_W-1:1]};
  end

  assign txd = frameReg[0];
endmodule

// File: rtl/uart_tx_ctrl.sv
module uart_tx_ctrl
  import uart_tx_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int TICKS_PER_BIT = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       baudTick,
  input  logic       txEnCmd,
  input  logic       txDisCmd,
  input  logic       wrValid,
  input  logic       twoStop,
  input  logic       autoRtsMode,
  input  logic       rtsSetCmd,
  input  logic       rtsClrCmd,
  output txStrobes_t strb,
  output logic       shiftBusy,
  output logic       rtsOut,
  output logic       txReady,
  output logic       txEmpty
);
  localparam int PH_W  = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
  localparam int BIT_W = $clog2(DATA_W + 3);
  localparam logic [PH_W-1:0]  PH_LAST   = PH_W'(TICKS_PER_BIT - 1);
  localparam logic [BIT_W-1:0] IDX_ONE   = BIT_W'(DATA_W + 1);
  localparam logic [BIT_W-1:0] IDX_TWO   = BIT_W'(DATA_W + 2);

  logic             txEn, holdValid, busy, frameTwo, rtsBit;
  logic [PH_W-1:0]  phase, dlyCnt;
  logic [BIT_W-1:0] bitIdx;
  logic             bitEnd, frameEnd, drained, armed, autoClr;

  assign bitEnd   = busy && baudTick && (phase == PH_LAST);
  assign frameEnd = bitEnd && (bitIdx == (frameTwo ? IDX_TWO : IDX_ONE));

  always_comb begin
    strb.holdLoad  = wrValid && txEn && !holdValid;
    strb.shiftLoad = baudTick && holdValid && (!busy || frameEnd);
    strb.shiftAdv  = bitEnd && !frameEnd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) txEn <= 1'b0;
    else if (txDisCmd) txEn <= 1'b0;
    else if (txEnCmd) txEn <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) holdValid <= 1'b0;
    else if (strb.holdLoad) holdValid <= 1'b1;
    else if (strb.shiftLoad) holdValid <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= 1'b0;
      frameTwo <= 1'b0;
      phase    <= '0;
      bitIdx   <= '0;
    end else if (strb.shiftLoad) begin
      busy     <= 1'b1;
      frameTwo <= twoStop;
      phase    <= '0;
      bitIdx   <= '0;
    end else begin
      if (frameEnd) busy <= 1'b0;
      if (busy && baudTick) phase <= (phase == PH_LAST) ? '0 : phase + 1'b1;
      if (strb.shiftAdv) bitIdx <= bitIdx + 1'b1;
    end
  end

  assign txReady   = txEn && !holdValid;
  assign txEmpty   = txReady && !busy;
  assign shiftBusy = busy;

  // Automatic request-to-send clear: counts one bit time of ticks once drained.
  assign drained = !txEn && !holdValid && !busy;
  assign armed   = autoRtsMode && rtsBit && drained;
  assign autoClr = armed && baudTick && (dlyCnt == PH_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dlyCnt <= '0;
    else if (rtsSetCmd || !armed) dlyCnt <= '0;
    else if (baudTick) dlyCnt <= (dlyCnt == PH_LAST) ? '0 : dlyCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rtsBit <= 1'b0;
    else if (rtsSetCmd) rtsBit <= 1'b1;
    else if (rtsClrCmd || autoClr) rtsBit <= 1'b0;
  end

  assign rtsOut = rtsBit;

  p_hold_kept_r3: assert property (@(posedge clk) disable iff (!rstN)
    holdValid && !strb.shiftLoad |=> holdValid);
  p_manual_rts_r9: assert property (@(posedge clk) disable iff (!rstN)
    !autoRtsMode && !rtsClrCmd && rtsBit |=> rtsBit);
  p_clear_after_drain_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rtsBit) && !$past(rtsClrCmd) |-> $past(drained));
  p_set_wins_r11: assert property (@(posedge clk) disable iff (!rstN)
    rtsSetCmd |=> rtsBit);
  p_status_masked_r4: assert property (@(posedge clk) disable iff (!rstN)
    txEmpty |-> txReady);
endmodule

// File: rtl/uart_tx_rts.sv
module uart_tx_rts
  import uart_tx_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int TICKS_PER_BIT = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baudTick,
  input  logic              txEnCmd,
  input  logic              txDisCmd,
  input  logic              wrValid,
  input  logic [DATA_W-1:0] wrData,
  input  logic              twoStop,
  input  logic              autoRtsMode,
  input  logic              rtsSetCmd,
  input  logic              rtsClrCmd,
  output logic              txd,
  output logic              rtsOut,
  output logic              txReady,
  output logic              txEmpty
);
  txStrobes_t strb;
  logic       shiftBusy;

  uart_tx_ctrl #(.DATA_W(DATA_W), .TICKS_PER_BIT(TICKS_PER_BIT)) u_ctrl (
    .clk(clk), .rstN(rstN), .baudTick(baudTick),
    .txEnCmd(txEnCmd), .txDisCmd(txDisCmd), .wrValid(wrValid),
    .twoStop(twoStop), .autoRtsMode(autoRtsMode),
    .rtsSetCmd(rtsSetCmd), .rtsClrCmd(rtsClrCmd),
    .strb(strb), .shiftBusy(shiftBusy), .rtsOut(rtsOut),
    .txReady(txReady), .txEmpty(txEmpty)
  );

  uart_tx_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .txd(txd)
  );

  p_idle_line_r2: assert property (@(posedge clk) disable iff (!rstN)
    !shiftBusy |-> txd);
  p_start_low_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(shiftBusy) |-> !txd);
endmodule

// File: tb/uart_tx_rts_tb.sv
module uart_tx_rts_tb;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int BITC = 12;  // 4 ticks per bit, one tick every 3 clocks

  logic clk = 0, rstN = 0, baudTick = 0;
  logic txEnCmd = 0, txDisCmd = 0, wrValid = 0, twoStop = 0, autoRtsMode = 0;
  logic rtsSetCmd = 0, rtsClrCmd = 0;
  logic [7:0] wrData = '0;
  logic txd, rtsOut, txReady, txEmpty;

  typedef struct { logic [7:0] d; bit two; } exp_t;
  exp_t expQ[$];
  int startLog[$];
  int total = 0, bad = 0, cyc = 0, tickCnt = 0, rtsFallCyc = -1;
  bit monBusy = 0, doneFlag = 0;
  logic prevRts = 0;

  uart_tx_rts u_dut (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .txEnCmd(txEnCmd), .txDisCmd(txDisCmd),
    .wrValid(wrValid), .wrData(wrData), .twoStop(twoStop), .autoRtsMode(autoRtsMode),
    .rtsSetCmd(rtsSetCmd), .rtsClrCmd(rtsClrCmd), .txd(txd), .rtsOut(rtsOut),
    .txReady(txReady), .txEmpty(txEmpty)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) begin
    tickCnt  = (tickCnt == 2) ? 0 : tickCnt + 1;
    baudTick = (tickCnt == 2);
    if (prevRts && !rtsOut) rtsFallCyc = cyc;
    prevRts = rtsOut;
  end

  task automatic check(bit ok, string req, string what, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic finishRun();
    if (!doneFlag) begin
      doneFlag = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk); sig = 1;
    @(negedge clk); sig = 0;
  endtask

  // Driver: writes a byte and pushes the frame it expects, if accepted.
  task automatic wrByte(logic [7:0] d, bit accepted);
    exp_t it;
    @(negedge clk);
    wrData = d; wrValid = 1;
    if (accepted) begin it.d = d; it.two = twoStop; expQ.push_back(it); end
    @(negedge clk); wrValid = 0;
  endtask

  task automatic waitIdle();
    while (expQ.size() != 0 || monBusy) @(negedge clk);
    repeat (8) @(negedge clk);
  endtask

  task automatic waitRdy();
    while (!txReady) @(negedge clk);
  endtask

  // Monitor: scoreboard pops the expected frame and compares each bit.
  initial forever begin
    exp_t it;
    logic [7:0] got;
    @(negedge clk);
    if (rstN && txd === 1'b0 && !monBusy) begin
      monBusy = 1;
      startLog.push_back(cyc);
      if (expQ.size() == 0) begin
        check(0, "R3", "unexpected frame", 1, 0);
        it.d = '0; it.two = 0;
      end else it = expQ.pop_front();
      repeat (BITC/2) @(negedge clk);
      check(txd == 0, "R2", "start bit", txd, 0);
      for (int i = 0; i < 8; i++) begin
        repeat (BITC) @(negedge clk);
        got[i] = txd;
      end
      check(got == it.d, "R2", "data bits", got, it.d);
      repeat (BITC) @(negedge clk);
      check(txd == 1, "R2", "stop bit 1", txd, 1);
      if (it.two) begin
        repeat (BITC) @(negedge clk);
        check(txd == 1, "R2", "stop bit 2", txd, 1);
      end
      monBusy = 0;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "WDOG", "watchdog expired", cyc, 0);
    finishRun();
  end

  initial begin
    int n0, s, d;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(txd == 1 && rtsOut == 0 && txReady == 0 && txEmpty == 0, "R1", "reset outputs",
          {txd, rtsOut, txReady, txEmpty}, 4'b1000);
    rstN = 1;
    repeat (3) @(negedge clk);
    check(txReady == 0, "R1", "disabled after reset", txReady, 0);

    // R12 enable, R4 status
    pulse(txEnCmd);
    check(txReady == 1 && txEmpty == 1, "R4", "enabled idle status", {txReady, txEmpty}, 2'b11);

    // R2 one stop bit
    wrByte(8'hA5, 1);
    check(txReady == 0 && txEmpty == 0, "R4", "holding full status", {txReady, txEmpty}, 2'b00);
    waitIdle();
    check(txEmpty == 1, "R4", "empty after frame", txEmpty, 1);

    // R2 two stop bits
    twoStop = 1;
    wrByte(8'h3C, 1);
    waitIdle();
    twoStop = 0;

    // R5 back to back
    n0 = startLog.size();
    wrByte(8'h11, 1);
    waitRdy();
    wrByte(8'h22, 1);
    waitIdle();
    check(startLog.size() == n0 + 2, "R5", "frame count", startLog.size() - n0, 2);
    if (startLog.size() == n0 + 2)
      check(startLog[n0+1] - startLog[n0] == 10*BITC, "R5", "start spacing",
            startLog[n0+1] - startLog[n0], 10*BITC);

    // R3 write while full ignored
    n0 = startLog.size();
    wrByte(8'h01, 1);
    waitRdy();
    wrByte(8'h02, 1);
    wrByte(8'h77, 0);
    check(txReady == 0, "R3", "still full", txReady, 0);
    waitIdle();
    check(startLog.size() == n0 + 2, "R3", "frames after full write", startLog.size() - n0, 2);

    // R4 disabled masks status; R3 write while disabled ignored
    pulse(txDisCmd);
    check(txReady == 0 && txEmpty == 0, "R4", "disabled status", {txReady, txEmpty}, 2'b00);
    n0 = startLog.size();
    wrByte(8'h99, 0);
    repeat (150) @(negedge clk);
    check(startLog.size() == n0 && txd == 1, "R3", "no frame while disabled", startLog.size() - n0, 0);

    // R6/R7 auto clear at end of message
    autoRtsMode = 1;
    pulse(txEnCmd);
    pulse(rtsSetCmd);
    rtsFallCyc = -1;
    n0 = startLog.size();
    wrByte(8'h5A, 1);
    waitRdy();
    wrByte(8'hC3, 1);
    pulse(txDisCmd);
    check(rtsOut == 1, "R7", "rts held while sending", rtsOut, 1);
    waitIdle();
    repeat (BITC + 4) @(negedge clk);
    check(startLog.size() == n0 + 2, "R6", "pending chars sent", startLog.size() - n0, 2);
    if (startLog.size() == n0 + 2)
      check(rtsFallCyc == startLog[n0+1] + 11*BITC, "R7", "auto clear cycle",
            rtsFallCyc, startLog[n0+1] + 11*BITC);
    check(rtsOut == 0, "R7", "rts cleared", rtsOut, 0);

    // R8 disable after completion
    pulse(txEnCmd);
    pulse(rtsSetCmd);
    wrByte(8'h0F, 1);
    waitIdle();
    repeat (40) @(negedge clk);
    check(rtsOut == 1, "R8", "rts held while enabled", rtsOut, 1);
    rtsFallCyc = -1;
    @(negedge clk); d = cyc; txDisCmd = 1;
    @(negedge clk); txDisCmd = 0;
    repeat (20) @(negedge clk);
    check(rtsFallCyc >= d + 10 && rtsFallCyc <= d + 14, "R8", "late disable clear", rtsFallCyc, d + 12);

    // R10 set during pending clear restarts the delay
    rtsFallCyc = -1;
    @(negedge clk); s = cyc; rtsSetCmd = 1;
    @(negedge clk); rtsSetCmd = 0;
    while (cyc < s + 6) @(negedge clk);
    rtsSetCmd = 1;
    @(negedge clk); rtsSetCmd = 0;
    while (cyc < s + 15) @(negedge clk);
    check(rtsOut == 1, "R10", "clear restarted", rtsOut, 1);
    while (cyc < s + 25) @(negedge clk);
    check(rtsOut == 0 && rtsFallCyc >= s + 16 && rtsFallCyc <= s + 20, "R10", "restarted clear cycle",
          rtsFallCyc, s + 18);

    // R9 manual mode
    autoRtsMode = 0;
    pulse(txEnCmd);
    pulse(rtsSetCmd);
    wrByte(8'h81, 1);
    waitIdle();
    pulse(txDisCmd);
    repeat (100) @(negedge clk);
    check(rtsOut == 1, "R9", "no auto clear in manual mode", rtsOut, 1);
    pulse(rtsClrCmd);
    check(rtsOut == 0, "R11", "software clear", rtsOut, 0);

    // R11 set beats clear
    @(negedge clk); rtsSetCmd = 1; rtsClrCmd = 1;
    @(negedge clk); rtsSetCmd = 0; rtsClrCmd = 0;
    check(rtsOut == 1, "R11", "set wins", rtsOut, 1);

    // R12 disable beats enable
    @(negedge clk); txEnCmd = 1; txDisCmd = 1;
    @(negedge clk); txEnCmd = 0; txDisCmd = 0;
    check(txReady == 0, "R12", "disable wins", txReady, 0);

    repeat (10) @(negedge clk);
    check(expQ.size() == 0, "R2", "scoreboard drained", expQ.size(), 0);
    finishRun();
  end
endmodule